// File: doc/BRIEF.md
# Timed Register Trigger Pattern Generator

This block plays a short list of byte pairs into one selected port register to produce precisely timed control sequences. Each pair holds the value to write followed by the pause, in microseconds, to hold before the next pair is handled. Because the pause lives in one byte, a single step can wait at most 255 microseconds.

A host pulses `start` with the number of pairs and the register to target. The block fetches each pair from a synchronous pattern memory, issues a one-cycle register write, then counts out the pause. The microsecond time base comes from a clock divider that restarts on every write, so each pause is exact to the clock. `busy` covers the run and `done` pulses once when it ends. Loading the pattern memory and any branching happen outside this block.

Top module: `trig_seq`

## Requirements
- R1: After reset `busy`, `done`, `wr_en` and `mem_rd` are low.
- R2: A start with a length of N > 0 pairs raises `busy` in the cycle after `start` is sampled. Pair k is read with its value byte at memory address 2k and its pause byte at address 2k+1. The memory returns data one cycle after a read request.
- R3: Each write is a one-cycle `wr_en` pulse. It carries the pair's value byte on `wr_data` and the register select captured at start on `wr_sel`.
- R4: The first write pulse is high 3 cycles after `busy` rises. Each later write follows the previous one by exactly D*CLK_PER_US + 3 cycles, where D is the previous pair's pause byte.
- R5: A pause byte of 0 adds no wait, so the next pair's write follows 3 cycles after the current one.
- R6: A pause byte of 255 gives a gap of exactly 255*CLK_PER_US + 3 cycles, the longest gap possible.
- R7: `done` pulses for one cycle, D*CLK_PER_US cycles after the last write, where D is the last pause byte. If that pause is 0, it pulses in the same cycle as the last write. `busy` is low from that cycle on.
- R8: A start with a length of 0 pulses `done` in the cycle after `start` is sampled. It makes no write and leaves `busy` low.
- R9: A start pulse while `busy` is high is ignored. No extra write occurs and `wr_sel` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run (ignored while busy) |
| start_len | input | LEN_W | Number of pairs to play |
| start_sel | input | REG_W | Target register select |
| mem_rd | output | 1 | Pattern memory read request |
| mem_addr | output | LEN_W+1 | Pattern memory byte address |
| mem_q | input | 8 | Pattern memory read data, one cycle after request |
| wr_en | output | 1 | Register write strobe |
| wr_sel | output | REG_W | Register being written |
| wr_data | output | 8 | Value written |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The bench builds the block with CLK_PER_US = 4, LEN_W = 5 and REG_W = 2. The small divider makes every pause a short multiple of four cycles, so an off-by-one in the divider phase or its restart shows up directly in the write-to-write spacing. It also brings the 255-microsecond maximum pause within 1020 cycles. The 5-bit length allows multi-pair patterns, the zero-length case, and an ignored second start with a different select in one short run.

// File: rtl/trig_seq_pkg.sv
// Shared definitions for the timed register trigger pattern generator.
// Assumes byte-wide pattern memory and register data.
package trig_seq_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_VAL,
        ST_FETCH_DLY,
        ST_EMIT,
        ST_PAUSE
    } step_state_e;
endpackage

// File: rtl/trig_us_tick.sv
// Microsecond tick divider.
// Produces a tick once every CLK_PER_US cycles. A restart forces the phase
// to zero, so the first tick falls exactly CLK_PER_US cycles later.
// Assumes CLK_PER_US >= 1.
module trig_us_tick #(
    parameter int CLK_PER_US = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam logic [CW-1:0] LAST_PHASE = CW'(CLK_PER_US - 1);

    logic [CW-1:0] phase;

    // Advance the phase, wrapping at the last phase or on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || phase == LAST_PHASE) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    // A tick is flagged in the last phase of each microsecond.
    always_comb tick = (phase == LAST_PHASE);
endmodule

// File: rtl/trig_step_ctl.sv
// Step controller. It fetches (value, pause) pairs, issues register writes
// and counts the pause in microsecond ticks.
// Assumes a synchronous memory whose data is valid one cycle after mem_rd.
// Write-to-write spacing is pause*CLK_PER_US + 3 cycles.
module trig_step_ctl
    import trig_seq_pkg::*;
#(
    parameter int LEN_W = 8,
    parameter int REG_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  start_len,
    input  logic [REG_W-1:0]  start_sel,
    input  logic              tick,
    input  logic [BYTE_W-1:0] mem_q,
    output logic              mem_rd,
    output logic [LEN_W:0]    mem_addr,
    output logic              wr_en,
    output logic [REG_W-1:0]  wr_sel,
    output logic [BYTE_W-1:0] wr_data,
    output logic              div_restart,
    output logic              busy,
    output logic              done
);
    step_state_e       state;
    logic [LEN_W-1:0]  pair_idx;
    logic [LEN_W-1:0]  pair_last;
    logic [BYTE_W-1:0] val_q;
    logic [BYTE_W-1:0] remain;
    logic              step_over;
    logic              last_pair;
    logic [LEN_W-1:0]  next_idx;

    // Decide whether the current pair is finished in this cycle.
    always_comb begin
        last_pair   = (pair_idx == pair_last);
        next_idx    = pair_idx + 1'b1;
        div_restart = (state == ST_EMIT);
        step_over   = ((state == ST_EMIT) && (mem_q == '0)) ||
                      ((state == ST_PAUSE) && tick && (remain == 8'd1));
    end

    // Sequence the fetch, write and pause phases of each pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            pair_idx  <= '0;
            pair_last <= '0;
            val_q     <= '0;
            remain    <= '0;
            mem_rd    <= 1'b0;
            mem_addr  <= '0;
            wr_en     <= 1'b0;
            wr_sel    <= '0;
            wr_data   <= '0;
            busy      <= 1'b0;
            done      <= 1'b0;
        end else begin
            mem_rd <= 1'b0;
            wr_en  <= 1'b0;
            done   <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        wr_sel <= start_sel;
                        if (start_len == '0) begin
                            done <= 1'b1;
                        end else begin
                            busy      <= 1'b1;
                            pair_idx  <= '0;
                            pair_last <= start_len - 1'b1;
                            mem_rd    <= 1'b1;
                            mem_addr  <= '0;
                            state     <= ST_FETCH_VAL;
                        end
                    end
                end
                ST_FETCH_VAL: begin
                    mem_rd   <= 1'b1;
                    mem_addr <= {pair_idx, 1'b1};
                    state    <= ST_FETCH_DLY;
                end
                ST_FETCH_DLY: begin
                    val_q <= mem_q;
                    state <= ST_EMIT;
                end
                ST_EMIT: begin
                    wr_en   <= 1'b1;
                    wr_data <= val_q;
                    remain  <= mem_q;
                    state   <= ST_PAUSE;
                end
                ST_PAUSE: begin
                    if (tick) begin
                        remain <= remain - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
            if (step_over) begin
                if (last_pair) begin
                    busy  <= 1'b0;
                    done  <= 1'b1;
                    state <= ST_IDLE;
                end else begin
                    pair_idx <= next_idx;
                    mem_rd   <= 1'b1;
                    mem_addr <= {next_idx, 1'b0};
                    state    <= ST_FETCH_VAL;
                end
            end
        end
    end
endmodule

// File: rtl/trig_seq.sv
// Timed register trigger pattern generator, top level.
// Plays start_len (value, pause) byte pairs from a synchronous pattern
// memory into the register chosen by start_sel. Each pause counts whole
// microseconds of CLK_PER_US clocks.
module trig_seq
    import trig_seq_pkg::*;
#(
    parameter int CLK_PER_US = 50,
    parameter int LEN_W      = 8,
    parameter int REG_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  start_len,
    input  logic [REG_W-1:0]  start_sel,
    output logic              mem_rd,
    output logic [LEN_W:0]    mem_addr,
    input  logic [BYTE_W-1:0] mem_q,
    output logic              wr_en,
    output logic [REG_W-1:0]  wr_sel,
    output logic [BYTE_W-1:0] wr_data,
    output logic              busy,
    output logic              done
);
    logic us_tick;
    logic div_restart;

    trig_us_tick #(
        .CLK_PER_US(CLK_PER_US)
    ) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(div_restart),
        .tick   (us_tick)
    );

    trig_step_ctl #(
        .LEN_W(LEN_W),
        .REG_W(REG_W)
    ) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_len  (start_len),
        .start_sel  (start_sel),
        .tick       (us_tick),
        .mem_q      (mem_q),
        .mem_rd     (mem_rd),
        .mem_addr   (mem_addr),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .div_restart(div_restart),
        .busy       (busy),
        .done       (done)
    );
endmodule

// File: rtl/trig_seq_chk.sv
// Protocol checker for trig_seq, attached through bind.
// Assumes it observes only the top-level ports.
module trig_seq_chk #(
    parameter int LEN_W = 8,
    parameter int REG_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [LEN_W-1:0] start_len,
    input logic             busy,
    input logic             done,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_sel,
    input logic             mem_rd
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !busy && !done && !wr_en && !mem_rd);

    // R2
    read_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> busy);

    // R3
    write_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R3
    write_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (busy || done));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8
    empty_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && start_len == '0) |=> (done && !busy));

    // R9
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(wr_sel)));
endmodule

bind trig_seq trig_seq_chk #(
    .LEN_W(LEN_W),
    .REG_W(REG_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .start_len(start_len),
    .busy     (busy),
    .done     (done),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .mem_rd   (mem_rd)
);

// File: tb/trig_seq_test.sv
// Scoreboard bench for trig_seq: the run task queues expected writes and
// done pulses with their cycle numbers; a monitor pops and compares them.
module trig_seq_test;
    localparam int DIV = 4;
    localparam int LW  = 5;
    localparam int RW  = 2;
    localparam int AW  = LW + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [LW-1:0] start_len = '0;
    logic [RW-1:0] start_sel = '0;
    logic          mem_rd;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_q;
    logic          wr_en;
    logic [RW-1:0] wr_sel;
    logic [7:0]    wr_data;
    logic          busy;
    logic          done;
    logic [7:0]    pmem [0:63];

    typedef struct {
        bit            is_done;
        int            at;
        logic [RW-1:0] sel;
        logic [7:0]    val;
        string         req;
    } exp_t;

    exp_t exp_q[$];
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;

    trig_seq #(.CLK_PER_US(DIV), .LEN_W(LW), .REG_W(RW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_len(start_len),
        .start_sel(start_sel), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_q(mem_q), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .busy(busy), .done(done)
    );

    always #10 clk = ~clk;

    // Synchronous pattern memory model: one cycle read latency.
    always @(posedge clk) if (mem_rd) mem_q <= pmem[mem_addr];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Monitor: compare each write and done pulse with the queue head.
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && wr_en) begin
            if (exp_q.size() == 0 || exp_q[0].is_done) begin
                check(1'b0, "R9", "unexpected write", int'(wr_data), -1);
            end else begin
                e = exp_q.pop_front();
                check(cyc == e.at, e.req, "write cycle", cyc, e.at);
                check(wr_data == e.val, "R3", "write data", int'(wr_data), int'(e.val));
                check(wr_sel == e.sel, "R3", "write select", int'(wr_sel), int'(e.sel));
            end
        end
        if (rst_n && done) begin
            if (exp_q.size() == 0 || !exp_q[0].is_done) begin
                check(1'b0, "R7", "unexpected done", cyc, -1);
            end else begin
                e = exp_q.pop_front();
                check(cyc == e.at, e.req, "done cycle", cyc, e.at);
                check(!busy, "R7", "busy at done", int'(busy), 0);
            end
        end
    end

    // Launch a run of n pairs from pmem and queue its expected results.
    task automatic run(input logic [RW-1:0] sel, input int n, input string req);
        int   c0;
        int   t;
        exp_t e;
        @(negedge clk);
        start = 1'b1;
        start_len = LW'(n);
        start_sel = sel;
        @(posedge clk);
        #1 c0 = cyc;
        if (n == 0) begin
            e = '{1'b1, c0, sel, 8'h00, "R8"};
            exp_q.push_back(e);
        end else begin
            t = c0 + 3;
            for (int k = 0; k < n; k++) begin
                e = '{1'b0, t, sel, pmem[2*k], req};
                exp_q.push_back(e);
                if (k == n - 1) begin
                    e = '{1'b1, t + int'(pmem[2*k+1]) * DIV, sel, 8'h00, "R7"};
                    exp_q.push_back(e);
                end
                t = t + int'(pmem[2*k+1]) * DIV + 3;
            end
        end
        @(negedge clk);
        start = 1'b0;
        if (n == 0) check(busy == 1'b0, "R8", "busy on empty run", int'(busy), 0);
        else        check(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
        wait (exp_q.size() == 0);
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R7", "busy after run", int'(busy), 0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) pmem[i] = 8'h00;
        repeat (3) @(negedge clk);
        check(!busy && !done && !wr_en && !mem_rd, "R1", "outputs in reset",
              int'({busy, done, wr_en, mem_rd}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done, "R1", "idle after reset", int'({busy, done}), 0);

        // R8: zero-length run.
        run(2'd2, 0, "R8");

        // R2 R4 R5: three pairs, pauses 2, 0, 1.
        pmem[0] = 8'hA5; pmem[1] = 8'd2;
        pmem[2] = 8'h3C; pmem[3] = 8'd0;
        pmem[4] = 8'hFF; pmem[5] = 8'd1;
        run(2'd1, 3, "R4");

        // R5 R7: last pause zero, done with the last write.
        pmem[0] = 8'h11; pmem[1] = 8'd3;
        pmem[2] = 8'h22; pmem[3] = 8'd0;
        run(2'd3, 2, "R5");

        // R6: maximum pause on a two-pair run.
        pmem[0] = 8'h5A; pmem[1] = 8'd255;
        pmem[2] = 8'h81; pmem[3] = 8'd0;
        run(2'd0, 2, "R6");

        // R9: second start during a run is ignored.
        pmem[0] = 8'h01; pmem[1] = 8'd5;
        pmem[2] = 8'h02; pmem[3] = 8'd5;
        pmem[4] = 8'h03; pmem[5] = 8'd5;
        fork
            run(2'd1, 3, "R9");
            begin
                repeat (10) @(negedge clk);
                start = 1'b1;
                start_len = LW'(2);
                start_sel = 2'd3;
                @(negedge clk);
                start = 1'b0;
                check(wr_sel == 2'd1, "R9", "select held", int'(wr_sel), 1);
            end
        join
        repeat (5) @(negedge clk);
        check(!busy && !done, "R9", "no extra run", int'({busy, done}), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule